// File: doc/BRIEF.md
# Masked-Write USB PHY Control Register Bank

This block is the register file that sits between a simple 32-bit register bus and a dual-port USB PHY wrapper. It holds the controls that software changes at run time: the mode bit that restricts the link to USB 2.0 signalling, the PIPE power-state request field, the UTMI suspend field and the line-state detect enable. It also returns live, read-only copies of the UTMI line state, the host-disconnect flag and the PIPE power state the PHY reports.

Every writable register uses a per-bit masked write. The upper half of the write word (bits 31:16) is a write-enable mask for the lower half (bits 15:0). Software can therefore change one field without first reading the register. A sticky detect flag records any change on the line-state input while detection is enabled. Software clears it by writing 1. The flag, gated by the enable, drives an interrupt that wakes software when a device is plugged in.

Reads are combinational. `bus_rdata_o` is valid in the same cycle as a read request (`bus_sel_i`=1, `bus_wr_i`=0) and is zero otherwise. Writes take effect at the clock edge that samples them.

Top module: `phyctl_regbank`

## Requirements
- R1: On a write to a mapped control register, bit n (0..15) of that register takes bit n of the write word only when bit n+16 of the write word is 1. Every other bit keeps its value.
- R2: Offset 0x20 holds the USB2-only mode bit in bit 15 (reset 0, output `u2_only_o`) and the PIPE power request in bits 14:0 (reset 0x0014, output `pipe_pwr_req_o`).
- R3: Offset 0x04 holds the 16-bit UTMI suspend field (reset 0x1452, output `utmi_susp_o`).
- R4: Offset 0x30 reads the line state in bits 5:4 and host disconnect in bit 7. Offset 0x34 reads the PIPE power state in bits 14:13. Writes to either offset change nothing.
- R5: Offset 0x40 bit 0 is the line-state detect enable (reset 0, output `det_en_o`).
- R6: The detect status (readable at offset 0x44 bit 0, reset 0) is set at the first clock edge at which the line state differs from its value at the previous edge while detect is enabled. It stays set until cleared. A change while detect is disabled does not set it.
- R7: A write to 0x44 with bit 16 and bit 0 both 1 clears the detect status. A write with either bit at 0 leaves it unchanged. A clear in the same cycle as a set condition wins, leaving the status 0.
- R8: `det_irq_o` is 1 exactly when detect enable and detect status are both 1. Clearing the enable drops the interrupt but keeps the status.
- R9: Read data bits 31:16 are always zero, and a read of any unmapped offset returns zero.
- R10: A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write word: mask in 31:16, data in 15:0 |
| bus_rdata_o | output | 32 | Read data, same cycle as the request |
| line_state_i | input | 2 | Live UTMI line state from the PHY |
| host_disc_i | input | 1 | Live host-disconnect indication |
| pipe_pwr_st_i | input | 2 | Live PIPE power state (P0..P3) |
| u2_only_o | output | 1 | USB2-only mode control |
| pipe_pwr_req_o | output | 15 | PIPE power request field |
| utmi_susp_o | output | 16 | UTMI suspend field |
| det_en_o | output | 1 | Line-state detect enable |
| det_irq_o | output | 1 | Line-state detect interrupt |

## Verification
Two functions of this block can act in one cycle: the hardware setting of the detect status, caused by a line-state change, and the software clear by a write-1 to offset 0x44. The bench arms detection, then changes the line state on the same falling edge on which it presents the clearing write. Both therefore reach the same rising edge. The result is judged one cycle later: the status read back at 0x44 must be 0 and the interrupt must be low. A further idle cycle follows to confirm that the status does not come back from the already-absorbed change.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
   localparam int BUS_W  = 32;
   localparam int HALF_W = 16;
   localparam int OFF_W  = 12;

   localparam logic [OFF_W-1:0] OFF_SUSP  = 12'h004;
   localparam logic [OFF_W-1:0] OFF_MODE  = 12'h020;
   localparam logic [OFF_W-1:0] OFF_LINE  = 12'h030;
   localparam logic [OFF_W-1:0] OFF_PWRST = 12'h034;
   localparam logic [OFF_W-1:0] OFF_DETEN = 12'h040;
   localparam logic [OFF_W-1:0] OFF_DETST = 12'h044;

   localparam int LS_W     = 2;
   localparam int LS_LO    = 4;
   localparam int HD_BIT   = 7;
   localparam int PWR_W    = 2;
   localparam int PWRST_LO = 13;
endpackage

// File: rtl/phyctl_mask_reg.sv
module phyctl_mask_reg #(
   parameter int            W   = 16,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1 || W > phyctl_pkg::HALF_W) begin : g_bad_w
         $error("phyctl_mask_reg: W must be 1..16");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               q_o[i] <= RST[i];
            else if (wr_i && mask_i[i])
               q_o[i] <= data_i[i];
         end

         AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !mask_i[i]) |=> (q_o[i] == $past(q_o[i])));  // R1
         AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && mask_i[i]) |=> (q_o[i] == $past(data_i[i])));  // R1
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_i |=> $stable(q_o[i]));  // R10
      end
   endgenerate
endmodule

// File: rtl/phyctl_line_detect.sv
module phyctl_line_detect #(
   parameter int LS_W        = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LS_W-1:0] ls_i,
   input  logic            det_en_i,
   input  logic            clr_req_i,
   output logic [LS_W-1:0] ls_sync_o,
   output logic            status_o
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("phyctl_line_detect: SYNC_STAGES must be 0..4");
      end
   endgenerate

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ls_sync_o = ls_i;
      end else begin : g_sync
         logic [LS_W-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= '0;
            end else begin
               stage_q[0] <= ls_i;
               for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
            end
         end
         assign ls_sync_o = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [LS_W-1:0] ls_prev_q;
   logic            changed;

   assign changed = (ls_sync_o != ls_prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ls_prev_q <= '0;
         status_o  <= 1'b0;
      end else begin
         ls_prev_q <= ls_sync_o;
         if (clr_req_i)
            status_o <= 1'b0;
         else if (det_en_i && changed)
            status_o <= 1'b1;
      end
   end

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req_i |=> !status_o);  // R7
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !clr_req_i) |=> status_o);  // R6
   AST_SET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en_i && changed && !clr_req_i) |=> status_o);  // R6
   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_en_i && !status_o) |=> !status_o);  // R6
endmodule

// File: rtl/phyctl_read_mux.sv
module phyctl_read_mux #(
   parameter int ADDR_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  rd_en_i,
   input  logic [ADDR_W-1:0]                     addr_i,
   input  logic [phyctl_pkg::HALF_W-1:0]         susp_i,
   input  logic [phyctl_pkg::HALF_W-1:0]         mode_i,
   input  logic [phyctl_pkg::LS_W-1:0]           ls_i,
   input  logic                                  hd_i,
   input  logic [phyctl_pkg::PWR_W-1:0]          pwrst_i,
   input  logic                                  det_en_i,
   input  logic                                  det_st_i,
   output logic [phyctl_pkg::BUS_W-1:0]          rdata_o
);
   import phyctl_pkg::*;

   logic [HALF_W-1:0] low_word;
   logic              hit;

   always_comb begin
      low_word = '0;
      hit      = 1'b1;
      case (addr_i)
         OFF_SUSP[ADDR_W-1:0]:  low_word = susp_i;
         OFF_MODE[ADDR_W-1:0]:  low_word = mode_i;
         OFF_LINE[ADDR_W-1:0]: begin
            low_word[LS_LO +: LS_W] = ls_i;
            low_word[HD_BIT]        = hd_i;
         end
         OFF_PWRST[ADDR_W-1:0]: low_word[PWRST_LO +: PWR_W] = pwrst_i;
         OFF_DETEN[ADDR_W-1:0]: low_word[0] = det_en_i;
         OFF_DETST[ADDR_W-1:0]: low_word[0] = det_st_i;
         default:               hit = 1'b0;
      endcase
   end

   assign rdata_o = rd_en_i ? {{(BUS_W-HALF_W){1'b0}}, low_word} : '0;

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[BUS_W-1:HALF_W] == '0);  // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !hit) |-> (rdata_o == '0));  // R9
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank #(
   parameter int           ADDR_W      = 8,
   parameter logic [15:0]  SUSP_RST    = 16'h1452,
   parameter logic [14:0]  PWR_REQ_RST = 15'h0014,
   parameter int           SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [1:0]        line_state_i,
   input  logic              host_disc_i,
   input  logic [1:0]        pipe_pwr_st_i,
   output logic              u2_only_o,
   output logic [14:0]       pipe_pwr_req_o,
   output logic [15:0]       utmi_susp_o,
   output logic              det_en_o,
   output logic              det_irq_o
);
   import phyctl_pkg::*;

   localparam int MIN_ADDR_W = 7;

   generate
      if (ADDR_W < MIN_ADDR_W || ADDR_W > OFF_W) begin : g_bad_addr
         $error("phyctl_regbank: ADDR_W must be 7..12");
      end
   endgenerate

   logic [HALF_W-1:0] wr_data, wr_mask;
   logic              wr_any, rd_any;
   logic              wr_susp, wr_mode, wr_deten, wr_detst;
   logic              clr_req, det_st;
   logic [LS_W-1:0]   ls_sync;
   logic [HALF_W-1:0] mode_q;

   assign wr_data  = bus_wdata_i[HALF_W-1:0];
   assign wr_mask  = bus_wdata_i[BUS_W-1:HALF_W];
   assign wr_any   = bus_sel_i &&  bus_wr_i;
   assign rd_any   = bus_sel_i && !bus_wr_i;
   assign wr_susp  = wr_any && (bus_addr_i == OFF_SUSP[ADDR_W-1:0]);
   assign wr_mode  = wr_any && (bus_addr_i == OFF_MODE[ADDR_W-1:0]);
   assign wr_deten = wr_any && (bus_addr_i == OFF_DETEN[ADDR_W-1:0]);
   assign wr_detst = wr_any && (bus_addr_i == OFF_DETST[ADDR_W-1:0]);
   assign clr_req  = wr_detst && wr_mask[0] && wr_data[0];

   phyctl_mask_reg #(.W(HALF_W), .RST(SUSP_RST)) u_susp (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_susp),
      .data_i(wr_data), .mask_i(wr_mask), .q_o(utmi_susp_o));

   phyctl_mask_reg #(.W(HALF_W), .RST({1'b0, PWR_REQ_RST})) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_mode),
      .data_i(wr_data), .mask_i(wr_mask), .q_o(mode_q));

   phyctl_mask_reg #(.W(1), .RST(1'b0)) u_deten (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_deten),
      .data_i(wr_data[0]), .mask_i(wr_mask[0]), .q_o(det_en_o));

   assign u2_only_o      = mode_q[HALF_W-1];
   assign pipe_pwr_req_o = mode_q[HALF_W-2:0];

   phyctl_line_detect #(.LS_W(LS_W), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .ls_i(line_state_i), .det_en_i(det_en_o),
      .clr_req_i(clr_req), .ls_sync_o(ls_sync), .status_o(det_st));

   assign det_irq_o = det_en_o & det_st;

   phyctl_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
      .clk(clk), .rst_n(rst_n), .rd_en_i(rd_any), .addr_i(bus_addr_i),
      .susp_i(utmi_susp_o), .mode_i(mode_q), .ls_i(ls_sync),
      .hd_i(host_disc_i), .pwrst_i(pipe_pwr_st_i), .det_en_i(det_en_o),
      .det_st_i(det_st), .rdata_o(bus_rdata_o));

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(det_en_o) |-> !det_irq_o);  // R8
   AST_DETST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (det_st && !clr_req) |=> det_st);  // R8
   AST_RESET_VALUES: assert property (@(posedge clk)
      !rst_n |=> (utmi_susp_o == SUSP_RST && !u2_only_o && !det_en_o && !det_irq_o));  // R3
endmodule

// File: tb/phyctl_regbank_bench.sv
`timescale 1ns/1ps
module phyctl_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  ls = 2'b00;
   logic        hd = 1'b0;
   logic [1:0]  pwr = 2'b00;
   logic        u2_only, det_en, det_irq;
   logic [14:0] pwr_req;
   logic [15:0] susp;
   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   phyctl_regbank u_phyctl_regbank (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .line_state_i(ls), .host_disc_i(hd), .pipe_pwr_st_i(pwr),
      .u2_only_o(u2_only), .pipe_pwr_req_o(pwr_req), .utmi_susp_o(susp),
      .det_en_o(det_en), .det_irq_o(det_irq));

   typedef struct packed {
      logic [7:0]  waddr;
      logic [31:0] wdat;
      logic [7:0]  raddr;
      logic [31:0] rexp;
      logic [7:0]  req;
   } vec_t;

   // each entry: write, then read back one offset
   localparam vec_t VECS [12] = '{
      '{8'h20, 32'h8000_8000, 8'h20, 32'h0000_8014, 8'd2},   // R2 mode bit
      '{8'h20, 32'h000F_0003, 8'h20, 32'h0000_8013, 8'd1},   // R1 partial mask
      '{8'h20, 32'h0000_FFFF, 8'h20, 32'h0000_8013, 8'd1},   // R1 empty mask
      '{8'h04, 32'hFFFF_0000, 8'h04, 32'h0000_0000, 8'd3},   // R3
      '{8'h04, 32'h00F0_ABCD, 8'h04, 32'h0000_00C0, 8'd1},   // R1
      '{8'h04, 32'hFF00_1234, 8'h04, 32'h0000_12C0, 8'd1},   // R1
      '{8'h40, 32'h0001_0001, 8'h40, 32'h0000_0001, 8'd5},   // R5
      '{8'h40, 32'h0000_0000, 8'h40, 32'h0000_0001, 8'd5},   // R5
      '{8'h50, 32'hFFFF_FFFF, 8'h50, 32'h0000_0000, 8'd9},   // R9 unmapped
      '{8'h30, 32'hFFFF_FFFF, 8'h20, 32'h0000_8013, 8'd10},  // R10
      '{8'h20, 32'h8000_0000, 8'h20, 32'h0000_0013, 8'd2},   // R2
      '{8'h40, 32'h0001_0000, 8'h40, 32'h0000_0000, 8'd5}    // R5
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      chk(tag, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      rd_chk("R2 reset 0x20", 8'h20, 32'h0000_0014);
      rd_chk("R3 reset 0x04", 8'h04, 32'h0000_1452);
      rd_chk("R5 reset 0x40", 8'h40, 32'h0);
      rd_chk("R6 reset 0x44", 8'h44, 32'h0);
      chk("R8 reset irq", {31'b0, det_irq}, 32'h0);
      chk("R3 reset susp out", {16'b0, susp}, 32'h1452);

      foreach (VECS[i]) begin
         bus_write(VECS[i].waddr, VECS[i].wdat);
         bus_read(VECS[i].raddr, v);
         chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].rexp);
      end
      chk("R2 outputs", {16'b0, u2_only, pwr_req}, 32'h0000_0013);
      chk("R3 susp output", {16'b0, susp}, 32'h0000_12C0);

      // R4 live status, writes ignored
      ls = 2'b10; hd = 1'b1; pwr = 2'b11;
      @(negedge clk);
      rd_chk("R4 line 0x30", 8'h30, 32'h0000_00A0);
      rd_chk("R4 pwrst 0x34", 8'h34, 32'h0000_6000);
      bus_write(8'h34, 32'hFFFF_FFFF);
      rd_chk("R4 pwrst after write", 8'h34, 32'h0000_6000);
      rd_chk("R4 mode unchanged", 8'h20, 32'h0000_0013);
      rd_chk("R9 rd unmapped 0x08", 8'h08, 32'h0);

      // R6 change while disabled
      ls = 2'b01;
      @(negedge clk);
      @(negedge clk);
      rd_chk("R6 no set when disabled", 8'h44, 32'h0);

      // R6 set while enabled
      bus_write(8'h40, 32'h0001_0001);
      ls = 2'b11;
      @(negedge clk);
      rd_chk("R6 set on change", 8'h44, 32'h1);
      chk("R8 irq high", {31'b0, det_irq}, 32'h1);
      repeat (5) @(negedge clk);
      rd_chk("R6 sticky", 8'h44, 32'h1);

      // R7 non-clearing writes
      bus_write(8'h44, 32'h0000_0001);
      rd_chk("R7 no mask no clear", 8'h44, 32'h1);
      bus_write(8'h44, 32'h0001_0000);
      rd_chk("R7 write 0 no clear", 8'h44, 32'h1);

      // R8 disable drops irq, keeps status
      bus_write(8'h40, 32'h0001_0000);
      chk("R8 irq low when disabled", {31'b0, det_irq}, 32'h0);
      rd_chk("R8 status kept", 8'h44, 32'h1);

      bus_write(8'h44, 32'h0001_0001);
      rd_chk("R7 cleared", 8'h44, 32'h0);

      // R7 clear and set in the same cycle
      bus_write(8'h40, 32'h0001_0001);
      @(negedge clk);
      ls = 2'b00;
      sel = 1'b1; wr = 1'b1; addr = 8'h44; wdata = 32'h0001_0001;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
      rd_chk("R7 clear wins", 8'h44, 32'h0);
      chk("R8 irq low after clear", {31'b0, det_irq}, 32'h0);
      @(negedge clk);
      rd_chk("R7 no late set", 8'h44, 32'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule